// File: doc/BRIEF.md
# Serial Flash Request Sequencer

This block turns a single high-level serial-flash request into the exact series of register accesses that an SPI master controller expects over AXI4-Lite. Four requests are supported: write enable, sector erase, page program and read. The requester supplies an operation code, a 24-bit flash address and a byte count. For a program request, it also pushes the payload bytes into a small on-block data FIFO. The sequencer then runs the whole access pattern on its own. It halts the master and flushes its FIFOs, loads the command, address and payload into the transmit register, and frames the transfer with slave select while the master is released. It polls the controller until the transfer has drained, restores the halted state and, for reads, pulls the received bytes back out.

The requester sees a busy flag while a sequence runs, a one-cycle done pulse at its end, and a one-cycle reject pulse for a request whose bytes would not fit in the controller's transmit FIFO. Read payload bytes come out on a byte port qualified by a valid strobe.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy, done, reqReject, rdValid, awValid, wValid and arValid are all low.
- R2: Every accepted request first writes 0x1E6 to register offset 0x60, the value that halts the master and flushes both of its FIFOs.
- R3: The transmit bytes are then written one per access to offset 0x68, zero-extended to 32 bits. The first byte is the command: reqOp 0 (write enable) sends 0x06 alone; reqOp 1 (erase) sends 0xD8; reqOp 2 (program) sends 0x02; reqOp 3 (read) sends 0x03. For erase, program and read, the command is followed by the address bytes, most significant first.
- R4: After the address, a program request sends reqCount bytes taken from the data FIFO in push order, and a read request sends reqCount dummy bytes of 0x00. When the data FIFO is empty, the sequencer waits and does not issue an access.
- R5: After the transmit bytes, the accesses follow a fixed order. First 0x00 is written to offset 0x70 and 0x086 to offset 0x60. Offset 0x64 is then read repeatedly until a response has bit 2 set (transmit empty) and bit 7 clear (shifter idle). Finally 0x01 is written to offset 0x70 and 0x186 to offset 0x60.
- R6: A read request then reads offset 0x6C 4+reqCount times. It discards the low bytes of the first four responses and presents the low byte of each later response on rdData with rdValid high for one cycle, in order.
- R7: A program or read request with 4+reqCount greater than TX_DEPTH is refused. reqReject pulses for one cycle, no bus access occurs, and busy stays low.
- R8: A request presented while busy is high is ignored and does not change the access sequence in progress.
- R9: done pulses for exactly one cycle per accepted request, in the cycle after the response of the final access, and busy is low in that cycle.
- R10: One bus access is outstanding at a time. awValid and wValid rise together, each stays high until its ready is seen, and the next access starts only after bValid or rValid has ended the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 2 | 0 write enable, 1 erase, 2 program, 3 read |
| reqAddr | input | 24 | Flash address |
| reqCount | input | CNT_W | Payload byte count |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| reqReject | output | 1 | One-cycle pulse for a refused request |
| dataIn | input | 8 | Program payload byte |
| dataValid | input | 1 | Push dataIn into the data FIFO |
| dataReady | output | 1 | Data FIFO has room |
| rdData | output | 8 | Read payload byte |
| rdValid | output | 1 | rdData is valid |
| awAddr | output | AW | Write address |
| awValid | output | 1 | Write address valid |
| awReady | input | 1 | Write address ready |
| wData | output | 32 | Write data |
| wValid | output | 1 | Write data valid |
| wReady | input | 1 | Write data ready |
| bValid | input | 1 | Write response valid |
| bReady | output | 1 | Write response ready |
| arAddr | output | AW | Read address |
| arValid | output | 1 | Read address valid |
| arReady | input | 1 | Read address ready |
| rData | input | 32 | Read data |
| rValid | input | 1 | Read data valid |
| rReady | output | 1 | Read data ready |

## Verification
The bench sends each request type to a bus model that stalls at random. The model answers status polls with both kinds of not-ready response, one with transmit data still pending and one with the shifter still busy. A sequencer that tested only one status bit would release slave select early, and the recorded access list would have fewer polls than expected. Program and read requests are sent with 4+reqCount exactly equal to the FIFO depth and one byte over it; an off-by-one in the capacity test shows up either as a refused legal request or as bus traffic for an illegal one. Other cases cover a program request whose payload arrives late, a read of zero bytes, and a request presented mid-sequence. These catch a design that issues a transmit access with stale FIFO data, that mis-counts the discarded receive bytes, or that restarts on a request arriving while it is busy.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {OP_WREN, OP_ERASE, OP_PROG, OP_READ} op_e;

  typedef enum logic [2:0] {RS_CTRL, RS_STAT, RS_TX, RS_RX, RS_SEL} reg_e;

  typedef enum logic [2:0] {
    DS_HALT_FLUSH, DS_RELEASE, DS_HALT, DS_SEL_ON, DS_SEL_OFF, DS_TXBYTE
  } dsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  go;
    logic  isRead;
    reg_e  regSel;
    dsel_e dataSel;
    logic  clrIdx;
    logic  incIdx;
    logic  latch;
  } ctl_s;

  function automatic logic [7:0] regOffset(reg_e r);
    case (r)
      RS_CTRL: return 8'h60;
      RS_STAT: return 8'h64;
      RS_TX:   return 8'h68;
      RS_RX:   return 8'h6C;
      default: return 8'h70;
    endcase
  endfunction

  function automatic logic [7:0] cmdByte(op_e op);
    case (op)
      OP_WREN:  return 8'h06;
      OP_ERASE: return 8'hD8;
      OP_PROG:  return 8'h02;
      default:  return 8'h03;
    endcase
  endfunction

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int TX_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [CNT_W-1:0] reqCount,
  input  logic             accDone,
  input  logic             lastIdx,
  input  logic             statOk,
  input  logic             needData,
  output ctl_s             ctl,
  output logic             busy,
  output logic             done,
  output logic             reqReject
);
  localparam int IW = CNT_W + 1;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_LOAD, ST_SELON, ST_REL, ST_POLL, ST_SELOFF, ST_INH, ST_DRAIN
  } st_e;

  st_e  state, stateNxt;
  logic isReadOp;
  logic tooBig, accept, finalDone;

  assign tooBig = (reqOp == OP_PROG || reqOp == OP_READ) &&
                  ((IW'(reqCount) + IW'(4)) > IW'(TX_DEPTH));
  assign accept = (state == ST_IDLE) && reqValid && !tooBig;

  always_comb begin
    ctl       = '0;
    stateNxt  = state;
    finalDone = 1'b0;
    case (state)
      ST_IDLE: begin
        ctl.latch  = accept;
        ctl.clrIdx = accept;
        if (accept) stateNxt = ST_CLR;
      end
      ST_CLR: begin
        ctl.go = 1'b1; ctl.regSel = RS_CTRL; ctl.dataSel = DS_HALT_FLUSH;
        if (accDone) stateNxt = ST_LOAD;
      end
      ST_LOAD: begin
        ctl.go = !needData; ctl.regSel = RS_TX; ctl.dataSel = DS_TXBYTE;
        ctl.incIdx = accDone && !lastIdx;
        if (accDone && lastIdx) stateNxt = ST_SELON;
      end
      ST_SELON: begin
        ctl.go = 1'b1; ctl.regSel = RS_SEL; ctl.dataSel = DS_SEL_ON;
        if (accDone) stateNxt = ST_REL;
      end
      ST_REL: begin
        ctl.go = 1'b1; ctl.regSel = RS_CTRL; ctl.dataSel = DS_RELEASE;
        if (accDone) stateNxt = ST_POLL;
      end
      ST_POLL: begin
        ctl.go = 1'b1; ctl.isRead = 1'b1; ctl.regSel = RS_STAT;
        if (accDone && statOk) stateNxt = ST_SELOFF;
      end
      ST_SELOFF: begin
        ctl.go = 1'b1; ctl.regSel = RS_SEL; ctl.dataSel = DS_SEL_OFF;
        if (accDone) stateNxt = ST_INH;
      end
      ST_INH: begin
        ctl.go = 1'b1; ctl.regSel = RS_CTRL; ctl.dataSel = DS_HALT;
        ctl.clrIdx = accDone;
        if (accDone) begin
          stateNxt  = isReadOp ? ST_DRAIN : ST_IDLE;
          finalDone = !isReadOp;
        end
      end
      ST_DRAIN: begin
        ctl.go = 1'b1; ctl.isRead = 1'b1; ctl.regSel = RS_RX;
        ctl.incIdx = accDone && !lastIdx;
        if (accDone && lastIdx) begin
          stateNxt  = ST_IDLE;
          finalDone = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isReadOp  <= 1'b0;
      done      <= 1'b0;
      reqReject <= 1'b0;
    end else begin
      state     <= stateNxt;
      done      <= finalDone;
      reqReject <= (state == ST_IDLE) && reqValid && tooBig;
      if (accept) isReadOp <= (reqOp == OP_READ);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/fcs_datapath.sv
module fcs_datapath
  import fcs_pkg::*;
#(
  parameter int AW         = 8,
  parameter int BASE       = 0,
  parameter int CNT_W      = 8,
  parameter int DATA_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctl_s             ctl,
  input  logic [1:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  output logic             dataReady,
  output logic             accDone,
  output logic             lastIdx,
  output logic             statOk,
  output logic             needData,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [AW-1:0]    awAddr,
  output logic             awValid,
  input  logic             awReady,
  output logic [31:0]      wData,
  output logic             wValid,
  input  logic             wReady,
  input  logic             bValid,
  output logic             bReady,
  output logic [AW-1:0]    arAddr,
  output logic             arValid,
  input  logic             arReady,
  input  logic [31:0]      rData,
  input  logic             rValid,
  output logic             rReady
);
  localparam int IW = CNT_W + 1;
  localparam int PW = $clog2(DATA_DEPTH);

  op_e              opQ;
  logic [23:0]      addrQ;
  logic [CNT_W-1:0] cntQ;
  logic [IW-1:0]    idx, totalBytes;
  logic             payloadPhase;

  // payload FIFO
  logic [7:0]  mem [DATA_DEPTH];
  logic [PW:0] wrPtr, rdPtr;
  logic        fifoEmpty, fifoFull, pop;

  assign fifoEmpty = (wrPtr == rdPtr);
  assign fifoFull  = (wrPtr[PW] != rdPtr[PW]) && (wrPtr[PW-1:0] == rdPtr[PW-1:0]);
  assign dataReady = !fifoFull;

  always_ff @(posedge clk) begin
    if (dataValid && !fifoFull) mem[wrPtr[PW-1:0]] <= dataIn;
  end

  // request latch and byte index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ <= OP_WREN; addrQ <= '0; cntQ <= '0; idx <= '0;
    end else begin
      if (ctl.latch) begin
        opQ <= op_e'(reqOp); addrQ <= reqAddr; cntQ <= reqCount;
      end
      if (ctl.clrIdx)      idx <= '0;
      else if (ctl.incIdx) idx <= idx + IW'(1);
    end
  end

  always_comb begin
    case (opQ)
      OP_WREN:  totalBytes = IW'(1);
      OP_ERASE: totalBytes = IW'(4);
      default:  totalBytes = IW'(cntQ) + IW'(4);
    endcase
  end

  assign lastIdx      = (idx == totalBytes - IW'(1));
  assign payloadPhase = (idx >= IW'(4));
  assign needData     = (opQ == OP_PROG) && payloadPhase && fifoEmpty;

  logic [7:0] txByte;
  always_comb begin
    case (idx)
      IW'(0):  txByte = cmdByte(opQ);
      IW'(1):  txByte = addrQ[23:16];
      IW'(2):  txByte = addrQ[15:8];
      IW'(3):  txByte = addrQ[7:0];
      default: txByte = (opQ == OP_PROG) ? mem[rdPtr[PW-1:0]] : 8'h00;
    endcase
  end

  logic [31:0] wordSel;
  always_comb begin
    case (ctl.dataSel)
      DS_HALT_FLUSH: wordSel = 32'h0000_01E6;
      DS_RELEASE:    wordSel = 32'h0000_0086;
      DS_HALT:       wordSel = 32'h0000_0186;
      DS_SEL_ON:     wordSel = 32'h0000_0000;
      DS_SEL_OFF:    wordSel = 32'h0000_0001;
      default:       wordSel = {24'h0, txByte};
    endcase
  end

  // single-outstanding bus engine
  logic          engBusy, engWr;
  logic [AW-1:0] busAddr;

  assign accDone = engBusy && (engWr ? bValid : rValid);
  assign bReady  = engBusy && engWr;
  assign rReady  = engBusy && !engWr;
  assign awAddr  = busAddr;
  assign arAddr  = busAddr;
  assign statOk  = rData[2] && !rData[7];
  assign pop     = accDone && (ctl.regSel == RS_TX) && (opQ == OP_PROG) && payloadPhase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      engBusy <= 1'b0; engWr <= 1'b0; busAddr <= '0; wData <= '0;
      awValid <= 1'b0; wValid <= 1'b0; arValid <= 1'b0;
      wrPtr <= '0; rdPtr <= '0; rdData <= '0; rdValid <= 1'b0;
    end else begin
      if (dataValid && !fifoFull) wrPtr <= wrPtr + 1'b1;
      if (pop) rdPtr <= rdPtr + 1'b1;
      rdValid <= accDone && (ctl.regSel == RS_RX) && payloadPhase;
      if (accDone && (ctl.regSel == RS_RX)) rdData <= rData[7:0];
      if (ctl.go && !engBusy) begin
        engBusy <= 1'b1;
        engWr   <= !ctl.isRead;
        busAddr <= AW'(BASE) + AW'(regOffset(ctl.regSel));
        wData   <= wordSel;
        awValid <= !ctl.isRead;
        wValid  <= !ctl.isRead;
        arValid <= ctl.isRead;
      end else begin
        if (awValid && awReady) awValid <= 1'b0;
        if (wValid && wReady)   wValid  <= 1'b0;
        if (arValid && arReady) arValid <= 1'b0;
        if (accDone)            engBusy <= 1'b0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{rData[31:8], rData[6:3], rData[1:0]};

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int AW         = 8,
  parameter int BASE       = 0,
  parameter int CNT_W      = 8,
  parameter int TX_DEPTH   = 16,
  parameter int DATA_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [23:0]      reqAddr,
  input  logic [CNT_W-1:0] reqCount,
  output logic             busy,
  output logic             done,
  output logic             reqReject,
  input  logic [7:0]       dataIn,
  input  logic             dataValid,
  output logic             dataReady,
  output logic [7:0]       rdData,
  output logic             rdValid,
  output logic [AW-1:0]    awAddr,
  output logic             awValid,
  input  logic             awReady,
  output logic [31:0]      wData,
  output logic             wValid,
  input  logic             wReady,
  input  logic             bValid,
  output logic             bReady,
  output logic [AW-1:0]    arAddr,
  output logic             arValid,
  input  logic             arReady,
  input  logic [31:0]      rData,
  input  logic             rValid,
  output logic             rReady
);
  ctl_s ctl;
  logic accDone, lastIdx, statOk, needData;

  fcs_ctrl #(.CNT_W(CNT_W), .TX_DEPTH(TX_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqCount(reqCount),
    .accDone(accDone), .lastIdx(lastIdx), .statOk(statOk), .needData(needData),
    .ctl(ctl), .busy(busy), .done(done), .reqReject(reqReject)
  );

  fcs_datapath #(.AW(AW), .BASE(BASE), .CNT_W(CNT_W), .DATA_DEPTH(DATA_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqCount(reqCount), .dataIn(dataIn), .dataValid(dataValid), .dataReady(dataReady),
    .accDone(accDone), .lastIdx(lastIdx), .statOk(statOk), .needData(needData),
    .rdData(rdData), .rdValid(rdValid),
    .awAddr(awAddr), .awValid(awValid), .awReady(awReady),
    .wData(wData), .wValid(wValid), .wReady(wReady),
    .bValid(bValid), .bReady(bReady),
    .arAddr(arAddr), .arValid(arValid), .arReady(arReady),
    .rData(rData), .rValid(rValid), .rReady(rReady)
  );

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic reqReject,
  input logic rdValid,
  input logic awValid,
  input logic awReady,
  input logic wValid,
  input logic wReady,
  input logic arValid,
  input logic arReady,
  input logic bReady,
  input logic rReady
);
  assert_aw_w_together_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awValid) |-> $rose(wValid));

  assert_aw_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (awValid && !awReady) |=> awValid);

  assert_ar_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (arValid && !arReady) |=> arValid);

  assert_single_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(arValid && (awValid || wValid)) && !(bReady && rReady));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_reject_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> !busy && !awValid && !arValid);

  assert_rd_in_seq_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (busy || done));

endmodule

bind flash_cmd_seq fcs_checker u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .reqReject(reqReject),
  .rdValid(rdValid), .awValid(awValid), .awReady(awReady), .wValid(wValid),
  .wReady(wReady), .arValid(arValid), .arReady(arReady), .bReady(bReady),
  .rReady(rReady)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
  localparam int TXD = 16;

  logic clk = 0, rstN = 0;
  always #2 clk = ~clk;

  logic reqValid = 0; logic [1:0] reqOp = 0; logic [23:0] reqAddr = 0; logic [7:0] reqCount = 0;
  logic busy, done, reqReject, dataReady, rdValid;
  logic [7:0] dataIn = 0, rdData; logic dataValid = 0;
  logic [7:0] awAddr, arAddr; logic awValid, wValid, bReady, arValid, rReady;
  logic [31:0] wData; logic [31:0] rData = 0;
  logic awReady = 0, wReady = 0, bValid = 0, arReady = 0, rValid = 0;

  flash_cmd_seq dut (.*);

  int errors = 0, checks = 0;
  // bus log
  logic        logWr [128]; logic [7:0] logAddr [128]; logic [31:0] logData [128];
  int logN = 0, pollsLeft = 0, rxIdx = 0; logic [7:0] rxBase = 0;
  // expected
  logic        expWr [128]; logic [7:0] expAddr [128]; logic [31:0] expData [128];
  int expN = 0;
  logic [7:0] progData [16];

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp); end
  endtask

  // bus slave model
  initial begin
    forever begin
      @(negedge clk);
      if (awValid && wValid) begin
        repeat ($urandom % 3) @(negedge clk);
        awReady = 1; wReady = 1;
        if (logN < 128) begin logWr[logN] = 1; logAddr[logN] = awAddr; logData[logN] = wData; end
        logN++;
        @(negedge clk); awReady = 0; wReady = 0;
        repeat ($urandom % 3) @(negedge clk);
        bValid = 1; @(negedge clk); bValid = 0;
      end else if (arValid) begin
        repeat ($urandom % 3) @(negedge clk);
        arReady = 1;
        if (logN < 128) begin logWr[logN] = 0; logAddr[logN] = arAddr; logData[logN] = 0; end
        logN++;
        if (arAddr == 8'h64) begin
          if (pollsLeft > 0) begin rData = pollsLeft[0] ? 32'h0 : 32'h84; pollsLeft--; end
          else rData = 32'h04;
        end else if (arAddr == 8'h6C) begin
          rData = {24'h0, rxBase + 8'(rxIdx)}; rxIdx++;
        end else rData = 32'hDEAD_BEEF;
        @(negedge clk); arReady = 0;
        repeat ($urandom % 3) @(negedge clk);
        rValid = 1; @(negedge clk); rValid = 0;
      end
    end
  end

  task automatic addExp(input bit w, input logic [7:0] a, input logic [31:0] d);
    expWr[expN] = w; expAddr[expN] = a; expData[expN] = d; expN++;
  endtask

  function automatic logic [7:0] opByte(input int op);
    case (op) 0: return 8'h06; 1: return 8'hD8; 2: return 8'h02; default: return 8'h03; endcase
  endfunction

  task automatic buildExp(input int op, input logic [23:0] a, input int cnt, input int polls);
    expN = 0;
    addExp(1, 8'h60, 32'h1E6);                            // R2
    addExp(1, 8'h68, {24'h0, opByte(op)});                 // R3
    if (op != 0) begin
      addExp(1, 8'h68, {24'h0, a[23:16]});
      addExp(1, 8'h68, {24'h0, a[15:8]});
      addExp(1, 8'h68, {24'h0, a[7:0]});
    end
    if (op >= 2) for (int i = 0; i < cnt; i++)             // R4
      addExp(1, 8'h68, (op == 2) ? {24'h0, progData[i]} : 32'h0);
    addExp(1, 8'h70, 32'h0);                               // R5
    addExp(1, 8'h60, 32'h086);
    for (int i = 0; i <= polls; i++) addExp(0, 8'h64, 0);
    addExp(1, 8'h70, 32'h1);
    addExp(1, 8'h60, 32'h186);
    if (op == 3) for (int i = 0; i < 4 + cnt; i++) addExp(0, 8'h6C, 0);  // R6
  endtask

  task automatic pushData(input int cnt);
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk); dataIn = progData[i]; dataValid = 1;
    end
    @(negedge clk); dataValid = 0;
  endtask

  task automatic runOp(input int op, input logic [23:0] a, input int cnt, input int polls,
                       input bit late, input bit poke);
    logic [7:0] got [32]; int gotN = 0; int doneCnt = 0; bit seen = 0; int t = 0;
    for (int i = 0; i < 16; i++) progData[i] = 8'($urandom);
    buildExp(op, a, cnt, polls);
    rxBase = 8'($urandom); rxIdx = 0; pollsLeft = polls; logN = 0;
    if (op == 2 && !late) pushData(cnt);
    @(negedge clk); reqValid = 1; reqOp = 2'(op); reqAddr = a; reqCount = 8'(cnt);
    fork
      begin if (op == 2 && late) begin repeat (30) @(negedge clk); pushData(cnt); end end
      begin
        while (!seen && t < 5000) begin
          @(negedge clk); t++;
          if (rdValid && gotN < 32) begin got[gotN] = rdData; gotN++; end
          if (done) begin
            seen = 1; doneCnt++;
            chk(!busy, "R9", "busy at done", busy, 0);
          end
          if (poke && t == 4) begin reqValid = 1; reqOp = 2'd1; reqAddr = ~a; reqCount = 0; end
          else reqValid = 0;
        end
      end
    join
    chk(seen, "R9", "done seen", seen, 1);
    repeat (12) begin @(negedge clk); if (done) doneCnt++; end
    chk(doneCnt == 1, "R9", "done count", doneCnt, 1);
    chk(logN == expN, poke ? "R8" : "R5", "access count", logN, expN);
    for (int i = 0; i < expN && i < logN; i++) begin
      chk(logWr[i] == expWr[i] && logAddr[i] == expAddr[i] && (!expWr[i] || logData[i] == expData[i]),
          (i == 0) ? "R2" : "R3", $sformatf("access %0d", i),
          {logWr[i], logAddr[i], logData[i]}, {expWr[i], expAddr[i], expData[i]});
    end
    chk(gotN == ((op == 3) ? cnt : 0), "R6", "read byte count", gotN, (op == 3) ? cnt : 0);
    for (int i = 0; i < gotN && op == 3; i++)
      chk(got[i] == 8'(rxBase + 8'(4 + i)), "R6", "read byte", got[i], 8'(rxBase + 8'(4 + i)));
  endtask

  task automatic runReject(input int op, input int cnt);
    logN = 0;
    @(negedge clk); reqValid = 1; reqOp = 2'(op); reqAddr = 24'h123456; reqCount = 8'(cnt);
    @(negedge clk); reqValid = 0;
    chk(reqReject, "R7", "reject pulse", reqReject, 1);
    chk(!busy, "R7", "busy on reject", busy, 0);
    @(negedge clk);
    chk(!reqReject, "R7", "reject one cycle", reqReject, 0);
    repeat (20) @(negedge clk);
    chk(logN == 0 && !busy, "R7", "no access after reject", logN, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !reqReject && !rdValid && !awValid && !wValid && !arValid,
        "R1", "reset outputs", {busy, done, reqReject, rdValid, awValid, wValid, arValid}, 0);
    rstN = 1;
    @(negedge clk);
    runOp(0, 24'h0, 0, 0, 0, 0);              // write enable
    runOp(1, 24'hA5C30F, 0, 2, 0, 0);         // erase, two polls of both kinds
    runOp(2, 24'h010203, TXD - 4, 1, 0, 0);   // program at FIFO capacity
    runOp(3, 24'hFFFFFF, TXD - 4, 3, 0, 0);   // read at capacity
    runOp(3, 24'h000100, 0, 0, 0, 0);         // read of zero bytes
    runOp(2, 24'h777777, 5, 0, 1, 0);         // late payload, R4 stall
    runOp(3, 24'h456789, 3, 1, 0, 1);         // request during busy, R8
    runReject(2, TXD - 3);                    // R7 boundary
    runReject(3, TXD - 3);
    runReject(3, 200);
    for (int k = 0; k < 10; k++) begin
      int op = $urandom % 4;
      runOp(op, 24'($urandom), (op >= 2) ? ($urandom % (TXD - 3)) : 0, $urandom % 4, 0, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule